// File: doc/BRIEF.md
# Window Threshold Watchdog Monitor

This block sits beside a converter's result path and inspects each result in the cycle it is presented. A result is examined only when it is in scope. Its group (regular or injected) must have monitoring switched on. When single-channel scoping is active, it must also come from the chosen channel. An in-scope result that lies strictly above the high threshold or strictly below the low threshold sets a sticky out-of-window flag. Software clears that flag with a one-cycle clear strobe. An interrupt request follows the flag, gated by its own enable.

Comparison is made on the raw converter code, before any alignment or offset step. The thresholds are therefore given in the same unaligned scale as the result. Both thresholds are inclusive bounds of the allowed window.

Top module: `win_watch`

## Requirements
- R1: After reset, `wd_flag` and `wd_irq` are 0.
- R2: An in-scope result with `res_val` greater than `thr_hi` sets `wd_flag` on the next rising clock edge.
- R3: An in-scope result with `res_val` less than `thr_lo` sets `wd_flag` on the next rising clock edge.
- R4: A result equal to `thr_hi`, equal to `thr_lo`, or between them does not set `wd_flag`.
- R5: With `mon_reg_en` and `mon_inj_en` both 0, no result sets `wd_flag`.
- R6: `res_inj`=0 marks a regular result, which is checked only when `mon_reg_en`=1. `res_inj`=1 marks an injected result, which is checked only when `mon_inj_en`=1.
- R7: With `one_chan`=1, only results whose `res_chan` equals `sel_chan` are checked, in either enabled group. With `one_chan`=0, every channel is checked.
- R8: `wd_flag` stays set until a cycle with `flag_clr`=1. It then reads 0 after the next rising edge.
- R9: When an in-scope out-of-window result and `flag_clr` arrive in the same cycle, the flag is set after the edge.
- R10: `wd_irq` is `wd_flag` ANDed with `irq_en`, with no added clock delay.
- R11: When `res_vld`=0, `res_val` and the other result inputs have no effect on `wd_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_vld | input | 1 | Result present this cycle |
| res_val | input | DATA_W | Raw unaligned converter code |
| res_chan | input | CHAN_W | Channel the result came from |
| res_inj | input | 1 | 1 = injected group, 0 = regular group |
| thr_hi | input | DATA_W | Upper bound of the window (inclusive) |
| thr_lo | input | DATA_W | Lower bound of the window (inclusive) |
| mon_reg_en | input | 1 | Check regular results |
| mon_inj_en | input | 1 | Check injected results |
| one_chan | input | 1 | Restrict checking to `sel_chan` |
| sel_chan | input | CHAN_W | Channel checked when `one_chan`=1 |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| wd_flag | output | 1 | Sticky out-of-window flag |
| wd_irq | output | 1 | Interrupt request |

## Verification
The flag is a single register, so the effect of any result or clear strobe is due exactly one rising edge after the cycle it was presented in. The interrupt is due in the same cycle as any change of `irq_en` or of the flag. The bench sets its inputs 1 ns after a rising edge and advances one edge. It then samples both outputs 1 ns later and compares them with a bench model updated from the inputs it has just driven. Directed cycles cover the threshold-equality, scoping and clear-versus-set corners. The random cycles bias values towards the thresholds.

// File: rtl/win_watch_pkg.sv
package win_watch_pkg;

    // Registered state of the monitor: the sticky out-of-window flag.
    typedef struct packed {
        logic flag;
    } wd_state_t;

    localparam wd_state_t WD_RESET = '{flag: 1'b0};

endpackage

// File: rtl/win_watch_scope.sv
// Decides whether the presented result is one the watchdog must examine.
module win_watch_scope #(
    parameter int CHAN_W = 5
) (
    input  logic              res_vld,
    input  logic              res_inj,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic              mon_reg_en,
    input  logic              mon_inj_en,
    input  logic              one_chan,
    input  logic [CHAN_W-1:0] sel_chan,
    output logic              in_scope
);

    logic group_on;
    logic chan_ok;

    always_comb begin
        group_on = res_inj ? mon_inj_en : mon_reg_en;
        chan_ok  = !one_chan || (res_chan == sel_chan);
        in_scope = res_vld && group_on && chan_ok;
    end

endmodule

// File: rtl/win_watch_cmp.sv
// Window comparison on the raw, unaligned code; bounds are inclusive.
module win_watch_cmp #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] res_val,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    output logic              above,
    output logic              below
);

    always_comb begin
        above = res_val > thr_hi;
        below = res_val < thr_lo;
    end

endmodule

// File: rtl/win_watch.sv
module win_watch
    import win_watch_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_vld,
    input  logic [DATA_W-1:0] res_val,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic              res_inj,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic              mon_reg_en,
    input  logic              mon_inj_en,
    input  logic              one_chan,
    input  logic [CHAN_W-1:0] sel_chan,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              wd_flag,
    output logic              wd_irq
);

    logic      in_scope;
    logic      above;
    logic      below;
    logic      hit;
    wd_state_t st_d;
    wd_state_t st_q;

    win_watch_scope #(.CHAN_W(CHAN_W)) u_scope (
        .res_vld    (res_vld),
        .res_inj    (res_inj),
        .res_chan   (res_chan),
        .mon_reg_en (mon_reg_en),
        .mon_inj_en (mon_inj_en),
        .one_chan   (one_chan),
        .sel_chan   (sel_chan),
        .in_scope   (in_scope)
    );

    win_watch_cmp #(.DATA_W(DATA_W)) u_cmp (
        .res_val (res_val),
        .thr_hi  (thr_hi),
        .thr_lo  (thr_lo),
        .above   (above),
        .below   (below)
    );

    // Next state: a clear strobe drops the flag, a fresh violation wins over it.
    always_comb begin
        hit  = in_scope && (above || below);
        st_d = st_q;
        if (flag_clr) begin
            st_d.flag = 1'b0;
        end
        if (hit) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WD_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign wd_flag = st_q.flag;
    assign wd_irq  = st_q.flag && irq_en;

endmodule

// File: rtl/win_watch_chk.sv
module win_watch_chk #(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_vld,
    input logic [DATA_W-1:0] res_val,
    input logic [CHAN_W-1:0] res_chan,
    input logic              res_inj,
    input logic [DATA_W-1:0] thr_hi,
    input logic [DATA_W-1:0] thr_lo,
    input logic              mon_reg_en,
    input logic              mon_inj_en,
    input logic              one_chan,
    input logic [CHAN_W-1:0] sel_chan,
    input logic              irq_en,
    input logic              flag_clr,
    input logic              wd_flag,
    input logic              wd_irq
);

    logic watched;
    assign watched = res_vld && (res_inj ? mon_inj_en : mon_reg_en)
                     && (!one_chan || res_chan == sel_chan);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !wd_flag);

    assert_above_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (watched && res_val > thr_hi) |=> wd_flag);

    assert_below_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (watched && res_val < thr_lo) |=> wd_flag);

    assert_inside_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_flag && res_val <= thr_hi && res_val >= thr_lo) |=> !wd_flag);

    assert_all_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_flag && !mon_reg_en && !mon_inj_en) |=> !wd_flag);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag && !flag_clr) |=> wd_flag);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !watched) |=> !wd_flag);

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> (wd_flag && irq_en));

    assert_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_vld && !wd_flag) |=> !wd_flag);

endmodule

bind win_watch win_watch_chk #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_vld    (res_vld),
    .res_val    (res_val),
    .res_chan   (res_chan),
    .res_inj    (res_inj),
    .thr_hi     (thr_hi),
    .thr_lo     (thr_lo),
    .mon_reg_en (mon_reg_en),
    .mon_inj_en (mon_inj_en),
    .one_chan   (one_chan),
    .sel_chan   (sel_chan),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .wd_flag    (wd_flag),
    .wd_irq     (wd_irq)
);

// File: tb/win_watch_bench.sv
`timescale 1ns/1ps
module win_watch_bench;

    localparam int DW = 12;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          res_vld = 1'b0;
    logic [DW-1:0] res_val = '0;
    logic [CW-1:0] res_chan = '0;
    logic          res_inj = 1'b0;
    logic [DW-1:0] thr_hi = 12'd3000;
    logic [DW-1:0] thr_lo = 12'd1000;
    logic          mon_reg_en = 1'b0;
    logic          mon_inj_en = 1'b0;
    logic          one_chan = 1'b0;
    logic [CW-1:0] sel_chan = '0;
    logic          irq_en = 1'b0;
    logic          flag_clr = 1'b0;
    logic          wd_flag;
    logic          wd_irq;

    int  checks = 0;
    int  errors = 0;
    bit  exp_flag = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    win_watch #(.DATA_W(DW), .CHAN_W(CW)) u_win_watch (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_val(res_val),
        .res_chan(res_chan), .res_inj(res_inj), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .mon_reg_en(mon_reg_en), .mon_inj_en(mon_inj_en), .one_chan(one_chan),
        .sel_chan(sel_chan), .irq_en(irq_en), .flag_clr(flag_clr),
        .wd_flag(wd_flag), .wd_irq(wd_irq)
    );

    // Reference model built from the requirements.
    function automatic bit model_next(bit cur);
        bit grp;
        bit chn;
        bit viol;
        grp  = res_inj ? mon_inj_en : mon_reg_en;
        chn  = !one_chan || (res_chan == sel_chan);
        viol = (res_val > thr_hi) || (res_val < thr_lo);
        if (res_vld && grp && chn && viol) return 1'b1;
        if (flag_clr) return 1'b0;
        return cur;
    endfunction

    task automatic check(input string tag);
        checks++;
        if (wd_flag !== exp_flag) begin
            errors++;
            $display("FAIL %s flag actual=%0b expected=%0b", tag, wd_flag, exp_flag);
        end
        checks++;
        if (wd_irq !== (exp_flag && irq_en)) begin
            errors++;
            $display("FAIL R10 (%s) irq actual=%0b expected=%0b", tag, wd_irq,
                     exp_flag && irq_en);
        end
    endtask

    // Inputs were set 1 ns after an edge; step to the next edge and sample 1 ns later.
    task automatic step(input string tag);
        exp_flag = model_next(exp_flag);
        @(posedge clk);
        #1;
        check(tag);
    endtask

    task automatic put(input bit v, input int val, input int ch, input bit inj, input bit clr);
        res_vld  = v;
        res_val  = DW'(val);
        res_chan = CW'(ch);
        res_inj  = inj;
        flag_clr = clr;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        check("R1");
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1");

        irq_en = 1'b1;
        mon_reg_en = 1'b1;
        put(1, 3001, 2, 0, 0); step("R2");       // just above high bound
        put(0, 0, 0, 0, 0);    step("R8");       // holds without clear
        put(0, 0, 0, 0, 1);    step("R8");       // clear
        put(1, 999, 4, 0, 0);  step("R3");       // just below low bound
        put(0, 0, 0, 0, 1);    step("R8");
        put(1, 3000, 1, 0, 0); step("R4");       // equal to high
        put(1, 1000, 1, 0, 0); step("R4");       // equal to low
        put(1, 2000, 1, 0, 0); step("R4");       // inside
        put(0, 4095, 1, 0, 0); step("R11");      // not valid
        mon_reg_en = 1'b0;
        put(1, 4095, 3, 0, 0); step("R5");
        put(1, 0, 3, 1, 0);    step("R5");
        mon_inj_en = 1'b1;
        put(1, 4095, 3, 0, 0); step("R6");       // regular ignored
        put(1, 4095, 3, 1, 0); step("R6");       // injected checked
        put(0, 0, 0, 0, 1);    step("R8");
        mon_reg_en = 1'b1;
        one_chan = 1'b1;
        sel_chan = 5'd7;
        put(1, 4095, 6, 1, 0); step("R7");       // other channel ignored
        put(1, 4095, 6, 0, 0); step("R7");
        put(1, 0, 7, 0, 0);    step("R7");       // selected, regular
        put(1, 0, 7, 1, 1);    step("R9");       // set beats clear
        irq_en = 1'b0;
        #1;
        check("R10");
        put(0, 0, 0, 0, 1);    step("R8");
        irq_en = 1'b1;
        one_chan = 1'b0;

        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 600; i++) begin
            int pick;
            int lo;
            int hi;
            lo = $urandom_range(0, 2000);
            hi = $urandom_range(lo, 4095);
            thr_lo = DW'(lo);
            thr_hi = DW'(hi);
            mon_reg_en = ($urandom_range(0, 3) != 0);
            mon_inj_en = ($urandom_range(0, 3) != 0);
            one_chan = $urandom_range(0, 1);
            sel_chan = CW'($urandom_range(0, 3));
            irq_en = $urandom_range(0, 1);
            pick = $urandom_range(0, 5);
            case (pick)
                0: res_val = DW'(hi);
                1: res_val = DW'(lo);
                2: res_val = (hi < 4095) ? DW'(hi + 1) : DW'(hi);
                3: res_val = (lo > 0) ? DW'(lo - 1) : DW'(lo);
                default: res_val = DW'($urandom_range(0, 4095));
            endcase
            res_vld  = ($urandom_range(0, 4) != 0);
            res_chan = CW'($urandom_range(0, 3));
            res_inj  = $urandom_range(0, 1);
            flag_clr = ($urandom_range(0, 3) == 0);
            step("R2/R3/R6/R7 random");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule